// File: doc/BRIEF.md
# Auxiliary Command Pulse Generator

This block sits behind one write-only command byte on a host bus. The host writes a command code with an active-low write strobe. The block moves the strobe and the data into the clock domain and acts once on the strobe's rising edge. Each recognised code either produces a local message or starts a fixed action that is timed in clocks.

A send-EOI request is held until the source handshake reports that it has sent a byte. A trigger produces an output pulse exactly one clock wide. A parallel-poll request keeps a busy level high for a fixed number of clocks and then gives a one-clock done strobe. Any other code does nothing.

Writes must be spaced at least four clocks apart. A write that arrives sooner is still carried out, but it sets a sticky status bit, which the host clears with a read strobe. The interface-clear and remote-enable bus lines are resynchronised and passed on as internal levels.

Top module: `aux_cmd_pulser`

## Requirements
- R1: After reset, every output is 0: send_eoi, trig, pp_busy, pp_done, early_wr, ifc_sync and ren_sync.
- R2: Code 0x06 sets send_eoi on the third rising clock edge after the rising edge of wr_n. send_eoi stays 1 until the clock edge that samples byte_sent high. If both happen on the same edge, the set wins.
- R3: Code 0x08 drives trig high for exactly one clock. The pulse starts on the third rising clock edge after the rising edge of wr_n.
- R4: Code 0x0D raises pp_busy on the third rising clock edge after the rising edge of wr_n. pp_busy stays high for exactly 40 clocks. pp_done is high for the single clock that follows.
- R5: A 0x0D write that is taken while pp_busy is high restarts the count. pp_busy then stays high, without a gap, for 40 clocks measured from the new start.
- R6: Every code other than 0x06, 0x08 and 0x0D leaves send_eoi, trig, pp_busy and pp_done unchanged.
- R7: The gap between two writes is counted in clocks between their wr_n rising edges. If the gap is less than 4, early_wr is set together with the second command's effect, and that command is still carried out. A gap of 4 or more leaves early_wr unchanged.
- R8: early_wr is sticky. It clears on the clock edge that samples status_rd high, unless a new early write is taken on that same edge.
- R9: ifc_sync and ren_sync follow ifc_in and ren_in with a latency of two clocks, which is within the four-clock limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_n | input | 1 | Active-low command write strobe, asynchronous to clk |
| wdata | input | 8 | Command byte, held stable while wr_n is low |
| byte_sent | input | 1 | Source handshake reports that a byte went out |
| status_rd | input | 1 | Host read of the status, clears early_wr |
| ifc_in | input | 1 | Interface-clear bus line |
| ren_in | input | 1 | Remote-enable bus line |
| send_eoi | output | 1 | Held request to send EOI with the next byte |
| trig | output | 1 | One-clock trigger pulse |
| pp_busy | output | 1 | Parallel poll in progress |
| pp_done | output | 1 | One-clock strobe at the end of a parallel poll |
| ifc_sync | output | 1 | Synchronised interface-clear level |
| ren_sync | output | 1 | Synchronised remote-enable level |
| early_wr | output | 1 | Sticky flag for writes spaced less than 4 clocks apart |

## Verification
Several faults look alike at the ports and show up only under timing checks. A wrong edge detector or a wrong data-capture point shows up three clocks after a write, as a missing action or as the action for the wrong code. A wrong poll counter shows up as a busy window that is not exactly 40 clocks long, or that has a gap after a restart. A wrong gap counter can only be told apart by the clock spacings of 3 and 4, which must be exercised on both sides of the threshold.

// File: rtl/aux_cmd_pulser.sv
module aux_cmd_pulser #(
  parameter int DW       = 8,
  parameter int MIN_GAP  = 4,
  parameter int PP_CLKS  = 40,
  parameter logic [DW-1:0] CMD_SEOI = 8'h06,
  parameter logic [DW-1:0] CMD_TRIG = 8'h08,
  parameter logic [DW-1:0] CMD_RPP  = 8'h0D
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_n,
  input  logic [DW-1:0] wdata,
  input  logic          byte_sent,
  input  logic          status_rd,
  input  logic          ifc_in,
  input  logic          ren_in,
  output logic          send_eoi,
  output logic          trig,
  output logic          pp_busy,
  output logic          pp_done,
  output logic          ifc_sync,
  output logic          ren_sync,
  output logic          early_wr
);

  localparam int GW = $clog2(MIN_GAP + 1);
  localparam int PW = $clog2(PP_CLKS);

  logic          wr_s1, wr_s2, wr_s3;
  logic [DW-1:0] d_s1, d_s2, cmd_q;
  logic          ifc_s1, ren_s1;
  logic [GW-1:0] gap_cnt;
  logic [PW-1:0] pp_cnt;

  logic wr_evt, seoi_evt, trig_evt, rpp_evt, too_soon;

  assign wr_evt   = wr_s2 & ~wr_s3;
  assign seoi_evt = wr_evt && (cmd_q == CMD_SEOI);
  assign trig_evt = wr_evt && (cmd_q == CMD_TRIG);
  assign rpp_evt  = wr_evt && (cmd_q == CMD_RPP);
  assign too_soon = wr_evt && (gap_cnt < GW'(MIN_GAP));

  // strobe and data synchronizers; capture data while strobe is low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_s1 <= 1'b1;
      wr_s2 <= 1'b1;
      wr_s3 <= 1'b1;
      d_s1  <= '0;
      d_s2  <= '0;
      cmd_q <= '0;
    end else begin
      wr_s1 <= wr_n;
      wr_s2 <= wr_s1;
      wr_s3 <= wr_s2;
      d_s1  <= wdata;
      d_s2  <= d_s1;
      if (!wr_s2) cmd_q <= d_s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ifc_s1   <= 1'b0;
      ifc_sync <= 1'b0;
      ren_s1   <= 1'b0;
      ren_sync <= 1'b0;
    end else begin
      ifc_s1   <= ifc_in;
      ifc_sync <= ifc_s1;
      ren_s1   <= ren_in;
      ren_sync <= ren_s1;
    end
  end

  // clocks since the last write, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      gap_cnt <= GW'(MIN_GAP);
    else if (wr_evt)
      gap_cnt <= GW'(1);
    else if (gap_cnt < GW'(MIN_GAP))
      gap_cnt <= gap_cnt + GW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      early_wr <= 1'b0;
    else if (too_soon)
      early_wr <= 1'b1;
    else if (status_rd)
      early_wr <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      send_eoi <= 1'b0;
      trig     <= 1'b0;
    end else begin
      trig <= trig_evt;
      if (seoi_evt)
        send_eoi <= 1'b1;
      else if (byte_sent)
        send_eoi <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pp_busy <= 1'b0;
      pp_done <= 1'b0;
      pp_cnt  <= '0;
    end else begin
      pp_done <= 1'b0;
      if (rpp_evt) begin
        pp_busy <= 1'b1;
        pp_cnt  <= '0;
      end else if (pp_busy) begin
        if (pp_cnt == PW'(PP_CLKS - 1)) begin
          pp_busy <= 1'b0;
          pp_done <= 1'b1;
        end else begin
          pp_cnt <= pp_cnt + PW'(1);
        end
      end
    end
  end

  assert_eoi_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_sent && !seoi_evt |=> !send_eoi);
  assert_trig_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);
  assert_trig_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig) |-> $past(wr_evt));
  assert_done_after_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pp_done |-> !pp_busy && $past(pp_busy));
  assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rpp_evt |=> pp_busy && pp_cnt == '0);
  assert_rd_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd && !wr_evt |=> !early_wr);
  assert_ifc_lat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ifc_sync != $past(ifc_sync) |-> ifc_sync == $past(ifc_in, 2));
  assert_ren_lat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ren_sync != $past(ren_sync) |-> ren_sync == $past(ren_in, 2));

endmodule

// File: tb/sim_aux_cmd_pulser.sv
module sim_aux_cmd_pulser;
  logic clk = 0, rst_n = 0, wr_n = 1, byte_sent = 0, status_rd = 0, ifc_in = 0, ren_in = 0;
  logic [7:0] wdata = 0;
  logic send_eoi, trig, pp_busy, pp_done, ifc_sync, ren_sync, early_wr;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  aux_cmd_pulser u0 (.clk, .rst_n, .wr_n, .wdata, .byte_sent, .status_rd, .ifc_in, .ren_in,
    .send_eoi, .trig, .pp_busy, .pp_done, .ifc_sync, .ren_sync, .early_wr);

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // wr_n rises on the last negedge; idle = negedges waited first
  task automatic wr(logic [7:0] code, int idle);
    repeat (idle) @(negedge clk);
    @(negedge clk); wdata = code; wr_n = 0;
    @(negedge clk); wr_n = 1;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk); #1;
  endtask

  task automatic t_reset();
    chk("R1 send_eoi", send_eoi, 0); chk("R1 trig", trig, 0);
    chk("R1 pp_busy", pp_busy, 0); chk("R1 pp_done", pp_done, 0);
    chk("R1 early_wr", early_wr, 0); chk("R1 ifc_sync", ifc_sync, 0);
    chk("R1 ren_sync", ren_sync, 0);
  endtask

  task automatic t_sync();
    @(negedge clk); ifc_in = 1; ren_in = 1;
    @(posedge clk); #1 chk("R9 ifc one clock", ifc_sync, 0);
    @(posedge clk); #1 chk("R9 ifc two clocks", ifc_sync, 1);
    chk("R9 ren two clocks", ren_sync, 1);
    @(negedge clk); ifc_in = 0;
    repeat (2) @(posedge clk); #1 chk("R9 ifc fall", ifc_sync, 0);
    chk("R9 ren held", ren_sync, 1);
  endtask

  task automatic t_trig();
    wr(8'h08, 4);
    repeat (2) @(posedge clk); #1 chk("R3 trig early", trig, 0);
    @(posedge clk); #1 chk("R3 trig high", trig, 1);
    @(posedge clk); #1 chk("R3 trig one clock", trig, 0);
  endtask

  task automatic t_eoi();
    wr(8'h06, 4); settle();
    chk("R2 eoi set", send_eoi, 1);
    repeat (5) @(posedge clk); #1 chk("R2 eoi held", send_eoi, 1);
    @(negedge clk); byte_sent = 1;
    @(negedge clk); byte_sent = 0;
    #1 chk("R2 eoi cleared", send_eoi, 0);
  endtask

  task automatic t_pp();
    int n = 0, done_seen = 0;
    wr(8'h0D, 4); settle();
    chk("R4 busy start", pp_busy, 1);
    while (pp_busy && n < 100) begin @(posedge clk); #1 n++; done_seen = pp_done; end
    chk("R4 busy length", n, 40);
    chk("R4 done strobe", done_seen, 1);
    @(posedge clk); #1 chk("R4 done one clock", pp_done, 0);
  endtask

  task automatic t_restart();
    int n = 0, gap = 0;
    wr(8'h0D, 4); settle();
    repeat (16) @(posedge clk);
    wr(8'h0D, 0);
    repeat (3) begin @(posedge clk); #1 if (!pp_busy) gap = 1; end
    chk("R5 no gap", gap, 0);
    while (pp_busy && n < 100) begin @(posedge clk); #1 n++; end
    chk("R5 restarted length", n, 40);
  endtask

  task automatic t_ignore();
    int hit = 0;
    wr(8'h05, 4); wr(8'h07, 2); wr(8'hFF, 2); wr(8'h0C, 2);
    repeat (6) begin
      @(posedge clk); #1 if (trig || send_eoi || pp_busy || pp_done) hit = 1;
    end
    chk("R6 ignored codes", hit, 0);
  endtask

  task automatic t_early();
    wr(8'h00, 6); wr(8'h08, 1); settle();
    chk("R7 gap3 executed", trig, 1);
    chk("R7 gap3 flagged", early_wr, 1);
    repeat (4) @(posedge clk); #1 chk("R8 sticky", early_wr, 1);
    @(negedge clk); status_rd = 1;
    @(negedge clk); status_rd = 0;
    #1 chk("R8 cleared by read", early_wr, 0);
    wr(8'h00, 6); wr(8'h08, 2); settle();
    chk("R7 gap4 executed", trig, 1);
    chk("R7 gap4 not flagged", early_wr, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 t_reset();
    rst_n = 1;
    t_sync(); t_trig(); t_eoi(); t_pp(); t_restart(); t_ignore(); t_early();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule